// File: doc/BRIEF.md
# Programmable Reference and Feedback Dividers with Phase-Frequency Detector

This block sits at the digital front of a clock-generation loop. Two square-wave inputs, a reference and a feedback signal, are sampled by a fast system clock. Each input goes through its own programmable counter, which produces a one-cycle pulse once every programmed number of input rising edges. A phase-frequency detector compares the two divided pulse trains and drives up and down requests for an external charge pump. It also drives an output enable that lets the pump output float.

Software-visible configuration arrives as plain input pins. The reference count is 14 bits wide and the feedback count is 13 bits wide. The other pins swap the detector sense, hold both counters at their start value, float the pump, and power the block down. A power-down comes from either a low chip-enable or a soft power-down bit. A digital lock indicator watches the width of the detector pulses. It asserts after a run of narrow comparisons and drops as soon as one pulse runs too long.

Top module: `pllDivPfd`

## Requirements
- R1: With reference count R (a value of 0 acts as 1), `refDivOut` gives exactly one single-cycle pulse for every R rising edges of `refIn`. After reset or a release from hold, the first pulse comes on the R-th edge.
- R2: The feedback divider behaves the same way with its 13-bit count N. N = 1 (and 0) passes every `fbIn` rising edge through as one pulse.
- R3: A divided pulse goes high one clock cycle after the clock edge that first samples the input high, and it lasts exactly one cycle.
- R4: While `counterHold` = 1, neither divided output pulses, whatever the input edges. After release, both counters start counting from zero.
- R5: With `polarityPos` = 1, a reference pulse sets `pumpUp` in the next cycle and a feedback pulse sets `pumpDown` in the next cycle. Each request stays high until the reset described in R7.
- R6: With `polarityPos` = 0, the two requests swap. A reference pulse drives `pumpDown` and a feedback pulse drives `pumpUp`.
- R7: Once both requests are high, they stay high together for exactly RST_DLY cycles (default 2) and then fall in the same cycle.
- R8: `pumpOe` is 0 whenever `pumpTriState` = 1, `chipEn` = 0 or `softPowerDown` = 1. A three-state request alone leaves the dividers running.
- R9: Power-down (`chipEn` = 0 or `softPowerDown` = 1) forces `pumpUp` and `pumpDown` low, holds both dividers and clears the lock indicator.
- R10: `lockDet` rises once LOCK_COUNT consecutive detector pulses (default 3) have each stayed active for no more than LOCK_WIDTH cycles (default 4). It stays low after one fewer.
- R11: `lockDet` falls in the cycle after a detector pulse reaches its (LOCK_WIDTH+1)-th active cycle. The run of narrow pulses then restarts from zero.
- R12: After reset, `refDivOut`, `fbDivOut`, `pumpUp`, `pumpDown` and `lockDet` are 0. `pumpOe` is 1 when the block is enabled and not floated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refIn | input | 1 | Reference square wave; each rising edge is one input cycle |
| fbIn | input | 1 | Feedback square wave; each rising edge is one input cycle |
| refCount | input | 14 | Reference division count (0 acts as 1) |
| fbCount | input | 13 | Feedback division count (0 acts as 1) |
| polarityPos | input | 1 | 1: reference drives up; 0: sense swapped |
| counterHold | input | 1 | 1: both dividers held at zero |
| pumpTriState | input | 1 | 1: pump output floated |
| chipEn | input | 1 | 0: block powered down |
| softPowerDown | input | 1 | 1: block powered down |
| refDivOut | output | 1 | Divided reference pulse |
| fbDivOut | output | 1 | Divided feedback pulse |
| pumpUp | output | 1 | Charge pump up request |
| pumpDown | output | 1 | Charge pump down request |
| pumpOe | output | 1 | Charge pump output enable |
| lockDet | output | 1 | Digital lock indicator |

## Verification
A divider counter that holds a wrong value shows up as a missing, extra or early divided pulse. This appears within one division period of the fault, so the bench counts pulses over whole periods for several count pairs, including the zero and pass-through cases. A detector flag that is stuck or cleared too early shows at the pump pins within a cycle or two. The bench therefore checks the up/down sense for both polarities and the exact length of the overlap cycle by cycle. A wrong pulse-width or run count in the lock logic only appears at the end of a comparison. It is caught by checking the indicator one comparison before and one after the threshold, and after a deliberately long pulse.

// File: rtl/pllDivPkg.sv
`timescale 1ns/1ps
package pllDivPkg;

  // Strobes from the control section to the divider datapath.
  typedef struct packed {
    logic holdDiv;   // force both counters to their start value
    logic clearPfd;  // wipe detector and lock state (power-down)
  } ctrlStrobeT;

endpackage

// File: rtl/pllCountDiv.sv
`timescale 1ns/1ps
module pllCountDiv #(
  parameter int W = 14
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         hold,
  input  logic         inEdge,
  input  logic [W-1:0] divisor,
  output logic         pulseOut
);

  logic [W-1:0] cnt;
  logic [W-1:0] lastIdx;

  // A zero divisor behaves as divide-by-one.
  always_comb lastIdx = (divisor == '0) ? '0 : divisor - W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      pulseOut <= 1'b0;
    end else if (hold) begin
      cnt      <= '0;
      pulseOut <= 1'b0;
    end else if (inEdge) begin
      if (cnt >= lastIdx) begin
        cnt      <= '0;
        pulseOut <= 1'b1;
      end else begin
        cnt      <= cnt + W'(1);
        pulseOut <= 1'b0;
      end
    end else begin
      pulseOut <= 1'b0;
    end
  end

  // R3: input edges are at least two cycles apart, so a pulse never repeats.
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    pulseOut |=> !pulseOut);

  // R4: a held counter produces nothing.
  assert_hold_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    hold |=> !pulseOut);

endmodule

// File: rtl/pllDivPath.sv
`timescale 1ns/1ps
module pllDivPath
  import pllDivPkg::*;
#(
  parameter int REF_W = 14,
  parameter int FB_W  = 13
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobeT       strobes,
  input  logic             refIn,
  input  logic             fbIn,
  input  logic [REF_W-1:0] refCount,
  input  logic [FB_W-1:0]  fbCount,
  output logic             refPulse,
  output logic             fbPulse
);

  logic refLast, fbLast;
  logic refEdge, fbEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refLast <= 1'b0;
      fbLast  <= 1'b0;
    end else begin
      refLast <= refIn;
      fbLast  <= fbIn;
    end
  end

  always_comb begin
    refEdge = refIn & ~refLast;
    fbEdge  = fbIn & ~fbLast;
  end

  pllCountDiv #(.W(REF_W)) refDiv (
    .clk      (clk),
    .rstN     (rstN),
    .hold     (strobes.holdDiv),
    .inEdge   (refEdge),
    .divisor  (refCount),
    .pulseOut (refPulse)
  );

  pllCountDiv #(.W(FB_W)) fbDiv (
    .clk      (clk),
    .rstN     (rstN),
    .hold     (strobes.holdDiv),
    .inEdge   (fbEdge),
    .divisor  (fbCount),
    .pulseOut (fbPulse)
  );

endmodule

// File: rtl/pllPfdCtrl.sv
`timescale 1ns/1ps
module pllPfdCtrl
  import pllDivPkg::*;
#(
  parameter int RST_DLY    = 2,
  parameter int LOCK_WIDTH = 4,
  parameter int LOCK_COUNT = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       counterHold,
  input  logic       powerDown,
  input  logic       pumpTriState,
  input  logic       polarityPos,
  input  logic       refPulse,
  input  logic       fbPulse,
  output ctrlStrobeT strobes,
  output logic       pumpUp,
  output logic       pumpDown,
  output logic       pumpOe,
  output logic       lockDet
);

  localparam int DLY_W  = $clog2(RST_DLY + 1);
  localparam int WID_W  = $clog2(LOCK_WIDTH + 2);
  localparam int GOOD_W = $clog2(LOCK_COUNT + 1);
  localparam int BR_W   = DLY_W + 1;
  localparam logic [DLY_W-1:0]  DLY_LAST  = DLY_W'(RST_DLY - 1);
  localparam logic [WID_W-1:0]  WID_LIM   = WID_W'(LOCK_WIDTH);
  localparam logic [WID_W-1:0]  WID_SAT   = WID_W'(LOCK_WIDTH + 1);
  localparam logic [GOOD_W-1:0] GOOD_MAX  = GOOD_W'(LOCK_COUNT);
  localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(LOCK_COUNT - 1);

  logic             upQ, dnQ;
  logic [DLY_W-1:0] dlyCnt;
  logic [WID_W-1:0] widthCnt;
  logic [GOOD_W-1:0] goodCnt;
  logic             lockQ;
  logic             active, overRun, pulseEnd;

  always_comb begin
    strobes.holdDiv  = counterHold | powerDown;
    strobes.clearPfd = powerDown;
  end

  // Detector flags: set by divided edges, cleared together after the overlap delay.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upQ    <= 1'b0;
      dnQ    <= 1'b0;
      dlyCnt <= '0;
    end else if (strobes.clearPfd) begin
      upQ    <= 1'b0;
      dnQ    <= 1'b0;
      dlyCnt <= '0;
    end else if (upQ && dnQ) begin
      if (dlyCnt == DLY_LAST) begin
        upQ    <= 1'b0;
        dnQ    <= 1'b0;
        dlyCnt <= '0;
      end else begin
        dlyCnt <= dlyCnt + DLY_W'(1);
      end
    end else begin
      if (refPulse) upQ <= 1'b1;
      if (fbPulse)  dnQ <= 1'b1;
      dlyCnt <= '0;
    end
  end

  // Lock detection by pulse width.
  always_comb begin
    active   = upQ | dnQ;
    overRun  = active && (widthCnt >= WID_LIM);
    pulseEnd = !active && (widthCnt != '0) && (widthCnt <= WID_LIM);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      widthCnt <= '0;
      goodCnt  <= '0;
      lockQ    <= 1'b0;
    end else if (strobes.clearPfd) begin
      widthCnt <= '0;
      goodCnt  <= '0;
      lockQ    <= 1'b0;
    end else begin
      if (active) begin
        if (widthCnt != WID_SAT) widthCnt <= widthCnt + WID_W'(1);
      end else begin
        widthCnt <= '0;
      end
      if (overRun) begin
        goodCnt <= '0;
        lockQ   <= 1'b0;
      end else if (pulseEnd) begin
        if (goodCnt != GOOD_MAX) goodCnt <= goodCnt + GOOD_W'(1);
        if (goodCnt >= GOOD_LAST) lockQ <= 1'b1;
      end
    end
  end

  always_comb begin
    pumpUp   = !powerDown && (polarityPos ? upQ : dnQ);
    pumpDown = !powerDown && (polarityPos ? dnQ : upQ);
    pumpOe   = !pumpTriState && !powerDown;
    lockDet  = lockQ;
  end

  // Checker state: length of the current overlap of both flags.
  logic [BR_W-1:0] bothRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bothRun <= '0;
    else if (upQ && dnQ) begin
      if (bothRun != '1) bothRun <= bothRun + BR_W'(1);
    end else bothRun <= '0;
  end

  // R7: the overlap never outlasts the reset delay.
  assert_overlap_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    bothRun <= BR_W'(RST_DLY));

  // R9: power-down silences the pump requests on the following cycle.
  assert_powerdown_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearPfd |=> (!pumpUp && !pumpDown && !lockDet));

  // R11: an over-long pulse drops the lock indicator.
  assert_lock_drop_R11: assert property (@(posedge clk) disable iff (!rstN)
    (active && widthCnt >= WID_LIM) |=> !lockDet);

endmodule

// File: rtl/pllDivPfd.sv
`timescale 1ns/1ps
module pllDivPfd
  import pllDivPkg::*;
#(
  parameter int REF_W      = 14,
  parameter int FB_W       = 13,
  parameter int RST_DLY    = 2,
  parameter int LOCK_WIDTH = 4,
  parameter int LOCK_COUNT = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refIn,
  input  logic             fbIn,
  input  logic [REF_W-1:0] refCount,
  input  logic [FB_W-1:0]  fbCount,
  input  logic             polarityPos,
  input  logic             counterHold,
  input  logic             pumpTriState,
  input  logic             chipEn,
  input  logic             softPowerDown,
  output logic             refDivOut,
  output logic             fbDivOut,
  output logic             pumpUp,
  output logic             pumpDown,
  output logic             pumpOe,
  output logic             lockDet
);

  ctrlStrobeT strobes;
  logic       powerDown;
  logic       refPulse, fbPulse;

  always_comb powerDown = !chipEn || softPowerDown;

  pllDivPath #(.REF_W(REF_W), .FB_W(FB_W)) dataPath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .refIn    (refIn),
    .fbIn     (fbIn),
    .refCount (refCount),
    .fbCount  (fbCount),
    .refPulse (refPulse),
    .fbPulse  (fbPulse)
  );

  pllPfdCtrl #(.RST_DLY(RST_DLY), .LOCK_WIDTH(LOCK_WIDTH), .LOCK_COUNT(LOCK_COUNT)) ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .counterHold  (counterHold),
    .powerDown    (powerDown),
    .pumpTriState (pumpTriState),
    .polarityPos  (polarityPos),
    .refPulse     (refPulse),
    .fbPulse      (fbPulse),
    .strobes      (strobes),
    .pumpUp       (pumpUp),
    .pumpDown     (pumpDown),
    .pumpOe       (pumpOe),
    .lockDet      (lockDet)
  );

  always_comb begin
    refDivOut = refPulse;
    fbDivOut  = fbPulse;
  end

endmodule

// File: tb/pllDivPfd_test.sv
`timescale 1ns/1ps
module pllDivPfd_test;

  logic        clk = 1'b0;
  logic        rstN;
  logic        refIn, fbIn;
  logic [13:0] refCount;
  logic [12:0] fbCount;
  logic        polarityPos, counterHold, pumpTriState, chipEn, softPowerDown;
  logic        refDivOut, fbDivOut, pumpUp, pumpDown, pumpOe, lockDet;

  int total = 0;
  int bad   = 0;
  int refSeen = 0;
  int fbSeen  = 0;

  always #2.5 clk = ~clk;

  pllDivPfd uut (
    .clk(clk), .rstN(rstN), .refIn(refIn), .fbIn(fbIn),
    .refCount(refCount), .fbCount(fbCount), .polarityPos(polarityPos),
    .counterHold(counterHold), .pumpTriState(pumpTriState), .chipEn(chipEn),
    .softPowerDown(softPowerDown), .refDivOut(refDivOut), .fbDivOut(fbDivOut),
    .pumpUp(pumpUp), .pumpDown(pumpDown), .pumpOe(pumpOe), .lockDet(lockDet)
  );

  typedef struct packed {
    logic [13:0] rc;
    logic [12:0] nc;
    logic [7:0]  refEdges;
    logic [7:0]  fbEdges;
    logic [7:0]  expRef;
    logic [7:0]  expFb;
  } vecT;

  localparam int NVEC = 6;
  localparam vecT VECS [NVEC] = '{
    '{14'd1, 13'd1,  8'd5,  8'd5,  8'd5, 8'd5},
    '{14'd3, 13'd4,  8'd12, 8'd12, 8'd4, 8'd3},
    '{14'd0, 13'd0,  8'd4,  8'd4,  8'd4, 8'd4},
    '{14'd5, 13'd2,  8'd11, 8'd7,  8'd2, 8'd3},
    '{14'd7, 13'd13, 8'd20, 8'd26, 8'd2, 8'd2},
    '{14'd2, 13'd1,  8'd9,  8'd3,  8'd4, 8'd3}
  };

  always @(negedge clk) begin
    if (refDivOut) refSeen++;
    if (fbDivOut)  fbSeen++;
  end

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic refEdges(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) refIn = 1'b1;
      @(negedge clk) refIn = 1'b0;
    end
  endtask

  task automatic fbEdges(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) fbIn = 1'b1;
      @(negedge clk) fbIn = 1'b0;
    end
  endtask

  task automatic pairEdge();
    @(negedge clk) begin refIn = 1'b1; fbIn = 1'b1; end
    @(negedge clk) begin refIn = 1'b0; fbIn = 1'b0; end
    idle(6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rstN = 1'b0; refIn = 1'b0; fbIn = 1'b0;
    refCount = 14'd1; fbCount = 13'd1;
    polarityPos = 1'b1; counterHold = 1'b0; pumpTriState = 1'b0;
    chipEn = 1'b1; softPowerDown = 1'b0;
    doReset();

    // R12 reset state
    check("R12 refDivOut after reset", int'(refDivOut), 0);
    check("R12 fbDivOut after reset", int'(fbDivOut), 0);
    check("R12 pumpUp after reset", int'(pumpUp), 0);
    check("R12 pumpDown after reset", int'(pumpDown), 0);
    check("R12 lockDet after reset", int'(lockDet), 0);
    check("R12 pumpOe after reset", int'(pumpOe), 1);

    // R1 R2 table of division ratios
    for (int v = 0; v < NVEC; v++) begin
      refCount = VECS[v].rc;
      fbCount  = VECS[v].nc;
      doReset();
      refSeen = 0;
      fbSeen  = 0;
      refEdges(int'(VECS[v].refEdges));
      fbEdges(int'(VECS[v].fbEdges));
      idle(3);
      check($sformatf("R1 ref pulses vec %0d", v), refSeen, int'(VECS[v].expRef));
      check($sformatf("R2 fb pulses vec %0d", v), fbSeen, int'(VECS[v].expFb));
    end

    // R3 R5 R7 timing with positive polarity
    refCount = 14'd1; fbCount = 13'd1; polarityPos = 1'b1;
    doReset();
    refIn = 1'b1;
    @(negedge clk);
    check("R3 ref pulse one cycle after sample", int'(refDivOut), 1);
    check("R5 up not yet set", int'(pumpUp), 0);
    refIn = 1'b0;
    @(negedge clk);
    check("R3 ref pulse lasts one cycle", int'(refDivOut), 0);
    check("R5 ref edge sets up", int'(pumpUp), 1);
    check("R5 down stays low", int'(pumpDown), 0);
    fbIn = 1'b1;
    @(negedge clk);
    check("R3 fb pulse one cycle after sample", int'(fbDivOut), 1);
    fbIn = 1'b0;
    @(negedge clk);
    check("R7 overlap cycle 1 up", int'(pumpUp), 1);
    check("R7 overlap cycle 1 down", int'(pumpDown), 1);
    @(negedge clk);
    check("R7 overlap cycle 2 up", int'(pumpUp), 1);
    check("R7 overlap cycle 2 down", int'(pumpDown), 1);
    @(negedge clk);
    check("R7 both cleared up", int'(pumpUp), 0);
    check("R7 both cleared down", int'(pumpDown), 0);

    // R6 swapped sense
    polarityPos = 1'b0;
    doReset();
    refEdges(1);
    idle(1);
    check("R6 ref edge drives down", int'(pumpDown), 1);
    check("R6 ref edge leaves up low", int'(pumpUp), 0);
    doReset();
    fbEdges(1);
    idle(1);
    check("R6 fb edge drives up", int'(pumpUp), 1);
    check("R6 fb edge leaves down low", int'(pumpDown), 0);
    polarityPos = 1'b1;

    // R4 counter hold
    refCount = 14'd2; fbCount = 13'd1;
    doReset();
    refEdges(1);
    counterHold = 1'b1;
    refSeen = 0; fbSeen = 0;
    refEdges(3);
    fbEdges(3);
    idle(3);
    check("R4 no ref pulse while held", refSeen, 0);
    check("R4 no fb pulse while held", fbSeen, 0);
    counterHold = 1'b0;
    idle(1);
    refEdges(1);
    idle(3);
    check("R4 ref restarts from zero", refSeen, 0);
    refEdges(1);
    idle(3);
    check("R4 ref pulse on second edge after release", refSeen, 1);

    // R8 three-state alone keeps dividers running
    doReset();
    pumpTriState = 1'b1;
    @(negedge clk);
    check("R8 tri-state disables pump", int'(pumpOe), 0);
    refSeen = 0;
    refEdges(2);
    idle(3);
    check("R8 dividers run while floated", refSeen, 1);
    pumpTriState = 1'b0;
    @(negedge clk);
    check("R8 pump enabled again", int'(pumpOe), 1);

    // R8 R9 power-down
    refCount = 14'd1;
    doReset();
    chipEn = 1'b0;
    @(negedge clk);
    check("R8 chip disable drops enable", int'(pumpOe), 0);
    refSeen = 0;
    refEdges(3);
    idle(3);
    check("R9 dividers held in power-down", refSeen, 0);
    check("R9 up stays low in power-down", int'(pumpUp), 0);
    chipEn = 1'b1;
    softPowerDown = 1'b1;
    @(negedge clk);
    check("R8 soft power-down drops enable", int'(pumpOe), 0);
    softPowerDown = 1'b0;

    // R10 R11 lock detect
    refCount = 14'd1; fbCount = 13'd1;
    doReset();
    pairEdge();
    pairEdge();
    check("R10 no lock after two narrow pulses", int'(lockDet), 0);
    pairEdge();
    check("R10 lock after three narrow pulses", int'(lockDet), 1);
    refEdges(1);
    idle(8);
    check("R11 lock drops on long pulse", int'(lockDet), 0);
    fbEdges(1);
    idle(6);
    pairEdge();
    pairEdge();
    check("R11 run restarts after long pulse", int'(lockDet), 0);
    pairEdge();
    check("R11 lock regained after full run", int'(lockDet), 1);

    // R9 power-down clears lock
    chipEn = 1'b0;
    idle(2);
    check("R9 lock cleared by power-down", int'(lockDet), 0);
    chipEn = 1'b1;
    idle(2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule